// File: doc/BRIEF.md
# Stall-Go Router Input Buffer with Empty-Queue Bypass

This block sits at one input port of a mesh router. It takes flits from the upstream router, holds them in a small first-in first-out store, and presents the oldest waiting flit to the switch stage. It paces the upstream sender with a single stall line instead of credits. The stall line rises when only one free slot is left, or when none are. A one-cycle release pulse follows every flit that leaves, so the sender can see that a slot has been freed.

When the store is empty, an arriving flit skips the write stage. It appears on the output in the cycle it arrives. If the switch stage takes it in that cycle, it is never stored. If the switch stage does not take it, it is written into the store and stays at the head. Every flit is 34 bits wide and carries its own destination, so the buffer forwards each one unchanged. There is no separate head flit.

Top module: `flit_stall_buffer`

## Requirements
- R1: While rst_ni is low and after it is released, the store is empty. buf_empty_o=1, buf_low_o=0, stall_up_o=0 and slot_free_o=0, and out_valid_o follows in_valid_i alone.
- R2: The store holds at most DEPTH=4 flits. With 4 stored and no dequeue, the output keeps presenting the same oldest flit.
- R3: stall_up_o is 1 exactly when 3 or 4 flits are stored, and 0 when fewer are stored.
- R4: slot_free_o is 1 for exactly one cycle, in the cycle after each cycle where deq_i and out_valid_o are both 1. At all other times it is 0.
- R5: buf_empty_o is 1 exactly when 0 flits are stored. buf_low_o is 1 exactly when 1 flit is stored.
- R6: With the store empty and in_valid_i=1, out_valid_o=1 and out_flit_o equals in_flit_i in the same cycle. If deq_i=1 in that cycle, the flit is consumed and the store stays empty.
- R7: A flit that is passed straight through but not dequeued in its arrival cycle is stored. It is presented as the output flit in the following cycle.
- R8: Flits leave in arrival order. When the store is non-empty, out_flit_o is the oldest stored flit and out_valid_o=1. A new arrival is appended behind the stored flits and never overtakes them.
- R9: When in_valid_i=1 while 4 flits are stored, drop_err_o=1 in that cycle and the flit is discarded. This holds even if a dequeue happens in the same cycle. drop_err_o is 0 at all other times.
- R10: The flit is 34 bits. Bit 33 is the tail flag, bits 32:30 are the next-port field, bits 29:21 hold the x, y and z destination coordinates (3 bits each), and bits 20:0 are the payload. All 34 bits pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A flit is offered by upstream this cycle |
| in_flit_i | input | 34 | Incoming flit |
| stall_up_o | output | 1 | Tells upstream to stop sending (one or no slot free) |
| deq_i | input | 1 | Switch stage takes the presented flit |
| out_flit_o | output | 34 | Oldest flit, or the arriving flit when the store is empty |
| out_valid_o | output | 1 | out_flit_o holds a flit |
| slot_free_o | output | 1 | One-cycle pulse after each flit leaves |
| buf_empty_o | output | 1 | No flit stored |
| buf_low_o | output | 1 | Exactly one flit stored |
| drop_err_o | output | 1 | Arriving flit discarded because the store is full |

## Verification
The bench targets the empty-store cycle, in both its dequeued and held forms. A faulty design would either duplicate the passed-through flit in storage or lose it. The bench also pushes into a full store, with and without a simultaneous dequeue. A faulty design there would overwrite the oldest flit or let the count wrap. Boundary occupancies of 1, 3 and 4 are visited to catch a stall or low-level threshold that is off by one. Mixed arrivals and dequeues check that a new flit never overtakes stored ones and that the release pulse is neither stretched nor skipped.

// File: rtl/flit_buf_pkg.sv
package flit_buf_pkg;
  localparam int TAIL_W    = 1;
  localparam int PORT_W    = 3;
  localparam int COORD_W   = 3;
  localparam int PAYLOAD_W = 21;
  localparam int FLIT_W    = TAIL_W + PORT_W + 3 * COORD_W + PAYLOAD_W;
  localparam int BUF_DEPTH = 4;
endpackage

// File: rtl/fb_store.sv
module fb_store #(
  parameter int DEPTH = 4,
  parameter int W     = 34,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_en_i,
  output logic [W-1:0]  rd_data_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q[g] <= '0;
      else if (wr_en_i && wr_ptr_q == PW'(g))   slot_q[g] <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (rd_en_i) rd_ptr_q <= nxt(rd_ptr_q);
      case ({wr_en_i, rd_en_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign rd_data_o = slot_q[rd_ptr_q];
  assign count_o   = count_q;

  assert_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_full_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CW'(DEPTH) && !rd_en_i) |=> (count_q == CW'(DEPTH) && $stable(rd_ptr_q)));
endmodule

// File: rtl/fb_status.sv
module fb_status #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic          fire_i,
  output logic          stall_o,
  output logic          empty_o,
  output logic          low_o,
  output logic          full_o,
  output logic          sent_o
);
  logic sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sent_q <= 1'b0;
    else         sent_q <= fire_i;
  end

  assign stall_o = count_i >= CW'(DEPTH - 1);
  assign full_o  = count_i == CW'(DEPTH);
  assign empty_o = count_i == '0;
  assign low_o   = count_i == CW'(1);
  assign sent_o  = sent_q;
endmodule

// File: rtl/flit_stall_buffer.sv
module flit_stall_buffer
  import flit_buf_pkg::*;
#(
  parameter int DEPTH = BUF_DEPTH,
  parameter int W     = FLIT_W,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_flit_i,
  output logic         stall_up_o,
  input  logic         deq_i,
  output logic [W-1:0] out_flit_o,
  output logic         out_valid_o,
  output logic         slot_free_o,
  output logic         buf_empty_o,
  output logic         buf_low_o,
  output logic         drop_err_o
);
  logic [CW-1:0] count;
  logic [W-1:0]  head;
  logic          empty, full, fire, wr_en, rd_en;

  assign out_valid_o = in_valid_i || !empty;
  assign out_flit_o  = empty ? in_flit_i : head;
  assign fire        = deq_i && out_valid_o;
  assign rd_en       = fire && !empty;
  // empty + dequeued: flit passes straight through, no write
  assign wr_en       = in_valid_i && !full && !(empty && deq_i);
  assign drop_err_o  = in_valid_i && full;

  fb_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (in_flit_i),
    .rd_en_i   (rd_en),
    .rd_data_o (head),
    .count_o   (count)
  );

  fb_status #(.DEPTH(DEPTH)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .count_i (count),
    .fire_i  (fire),
    .stall_o (stall_up_o),
    .empty_o (empty),
    .low_o   (buf_low_o),
    .full_o  (full),
    .sent_o  (slot_free_o)
  );

  assign buf_empty_o = empty;

  assert_sent_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_i && out_valid_o) |=> slot_free_o);
  assert_sent_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(deq_i && out_valid_o) |=> !slot_free_o);
  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_empty_o && in_valid_i && deq_i) |=> buf_empty_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_empty_o && in_valid_i && !deq_i) |=> (buf_low_o && out_flit_o == $past(in_flit_i)));
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_err_o && !deq_i) |=> (stall_up_o && !buf_low_o && $stable(out_flit_o)));
  assert_stall_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_up_o) |-> $past(in_valid_i));
endmodule

// File: tb/flit_stall_buffer_test.sv
module flit_stall_buffer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [33:0] in_flit_i = '0;
  logic        deq_i = 1'b0;
  logic        stall_up_o, out_valid_o, slot_free_o, buf_empty_o, buf_low_o, drop_err_o;
  logic [33:0] out_flit_o;

  always #2 clk_i = ~clk_i;

  flit_stall_buffer uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_flit_i(in_flit_i),
    .stall_up_o(stall_up_o), .deq_i(deq_i), .out_flit_o(out_flit_o),
    .out_valid_o(out_valid_o), .slot_free_o(slot_free_o), .buf_empty_o(buf_empty_o),
    .buf_low_o(buf_low_o), .drop_err_o(drop_err_o)
  );

  logic [33:0] q[$];
  bit sent_exp = 1'b0;
  bit held_prev = 1'b0;
  int checks = 0, errors = 0, seq = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] make_flit();
    seq++;
    return {seq[0], 3'(seq % 5), 3'(seq), 3'(seq >> 1), 3'(seq >> 2), 21'(seq * 37 + 5)};
  endfunction

  task automatic step(input bit v, input bit d);
    logic [33:0] f, exp_flit;
    bit exp_valid, fire, was_empty;
    int sz;
    f = make_flit();
    @(negedge clk_i);
    in_valid_i = v; in_flit_i = f; deq_i = d;
    #1;
    sz = q.size();
    exp_valid = v || sz > 0;
    exp_flit  = (sz > 0) ? q[0] : f;
    chk(out_valid_o == exp_valid, (sz == 0) ? "R6 valid" : "R8 valid", out_valid_o, exp_valid);
    if (exp_valid) begin
      chk(out_flit_o == exp_flit,
          held_prev ? "R7 held flit" : (sz == 0) ? "R6 bypass flit" : (sz == 4) ? "R2 full head" : "R8 order",
          out_flit_o, exp_flit);
      chk(out_flit_o[33] == exp_flit[33] && out_flit_o[20:0] == exp_flit[20:0], "R10 fields",
          out_flit_o, exp_flit);
    end
    chk(stall_up_o == (sz >= 3), "R3 stall", stall_up_o, sz >= 3);
    chk(buf_empty_o == (sz == 0), "R5 empty", buf_empty_o, sz == 0);
    chk(buf_low_o == (sz == 1), "R5 low", buf_low_o, sz == 1);
    chk(drop_err_o == (v && sz == 4), "R9 drop", drop_err_o, v && sz == 4);
    chk(slot_free_o == sent_exp, "R4 release", slot_free_o, sent_exp);
    @(posedge clk_i);
    fire = d && exp_valid;
    was_empty = (sz == 0);
    if (fire && sz > 0) void'(q.pop_front());
    if (v && sz < 4 && !(was_empty && d)) q.push_back(f);
    held_prev = v && was_empty && !d;
    sent_exp = fire;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(buf_empty_o == 1'b1, "R1 empty", buf_empty_o, 1);
    chk(buf_low_o == 1'b0, "R1 low", buf_low_o, 0);
    chk(stall_up_o == 1'b0, "R1 stall", stall_up_o, 0);
    chk(slot_free_o == 1'b0, "R1 release", slot_free_o, 0);
    chk(out_valid_o == 1'b0, "R1 valid", out_valid_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // bypass consumed, then held
    step(1, 1); step(1, 1); step(0, 0);
    step(1, 0); step(0, 1); step(0, 0);
    // fill to full and beyond
    step(1, 0); step(1, 0); step(1, 0); step(1, 0);
    step(1, 0); step(1, 0); step(0, 0);
    // full with simultaneous dequeue and arrival
    step(1, 1); step(0, 0);
    // drain
    step(0, 1); step(0, 1); step(0, 1); step(0, 1); step(0, 1); step(0, 0);
    // steady flow through non-empty store
    step(1, 0); step(1, 1); step(1, 1); step(1, 1); step(0, 1); step(0, 1); step(0, 0);
    for (int i = 0; i < 400; i++) step(1'($urandom % 3 != 0), 1'($urandom % 2));
    for (int i = 0; i < 6; i++) step(0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule